// File: doc/BRIEF.md
# Lamp Ballast Start Sequencer

This block is the digital start controller of a resonant half-bridge ballast for fluorescent tubes. It runs on a system clock and tells an external oscillator which frequency to produce, through a two-bit frequency-select code and a sweep step index. It also tells the gate drivers whether the half-bridge may switch. After a power-on pulse it heats the filaments at a high frequency for a fixed time. It then steps the frequency down towards the resonant strike point and holds it there while it waits for the tube to fire. When the tube fires, the block moves at once to the steady operating frequency.

A strike is signalled by a falling edge on the comparator input. The input must first have been high for a minimum number of synchronised cycles. If the tube does not fire, the sweep-and-hold cycle is repeated after a blanking gap, up to a fixed number of attempts in all. After the last attempt the block latches off. A low level on the reset pin turns the bridge off at once. On release of that pin the block restarts with the sweep and skips the filament heating, which only a power-on pulse arms. All intervals are parameters counted in clock cycles. The heating time is a fixed multiple of the attempt period, so both come from one timebase.

Frequency-select encoding: 2'b00 heating frequency f1 (also used in blanking, idle and stop), 2'b01 sweep, 2'b10 end-of-sweep frequency f2, 2'b11 operating frequency f3.

Top module: `lamp_start_seq`

## Requirements
- R1: After `por` falls with `rst_n` high, `preheat_o` is 1 and `freq_sel` is 2'b00 for exactly PH_RATIO*RECYCLE_CYC cycles, after which `freq_sel` becomes 2'b01.
- R2: When `rst_n` is released after a pin reset, and no `por` pulse has armed heating since the last heating, the block goes straight to the sweep (`freq_sel` 2'b01) and `preheat_o` never rises.
- R3: During a sweep `freq_sel` is 2'b01 for STEP_CYC*SWEEP_STEPS cycles. In sweep cycle i (counted from 0), `sweep_step` equals SWEEP_STEPS-1-floor(i/STEP_CYC), so it never rises.
- R4: After the sweep `freq_sel` is 2'b10 for RECYCLE_CYC-STEP_CYC*SWEEP_STEPS cycles, unless a strike ends that time early.
- R5: A falling edge of `strike_in` during the sweep or the f2 hold is accepted as a strike if `strike_in` was high for at least MIN_HIGH_CYC clock cycles before it. The output shows 2'b11 with `running_o`=1 and `bridge_en`=1 from the third clock edge after the edge is driven, not earlier. The block stays there until a reset.
- R6: A high pulse on `strike_in` shorter than MIN_HIGH_CYC cycles is not taken as a strike.
- R7: Falling edges of `strike_in` during filament heating or during blanking have no effect: heating and blanking run to their full length and are followed by a sweep.
- R8: Between one failed attempt and the next, the block blanks for BLANK_CYC cycles with `freq_sel` 2'b00, the bridge enabled and `preheat_o` 0.
- R9: After MAX_TRIES attempts without a strike, `stopped_o` is 1 and `bridge_en` is 0. The block stays there, whatever `strike_in` does, until `rst_n` goes low or `por` is pulsed.
- R10: While `rst_n` is low, `bridge_en` is 0 with no clock edge needed. All status flags are 0 by the third clock edge after `rst_n` falls.
- R11: While `por` is high and just after it, `bridge_en`, `preheat_o`, `running_o` and `stopped_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por | input | 1 | Power-on / undervoltage-release pulse, active high, asynchronous; arms filament heating |
| rst_n | input | 1 | Asynchronous active-low restart pin; forces the bridge off |
| strike_in | input | 1 | Strike-detect comparator level, asynchronous |
| freq_sel | output | 2 | Frequency select: 00 f1, 01 sweep, 10 f2, 11 f3 |
| sweep_step | output | $clog2(SWEEP_STEPS) | Sweep index, SWEEP_STEPS-1 at f1 down to 0 at f2 |
| bridge_en | output | 1 | Half-bridge switching enable |
| preheat_o | output | 1 | Filament heating in progress |
| running_o | output | 1 | Tube struck, operating frequency selected |
| stopped_o | output | 1 | Latched off after all attempts failed |

## Verification
The hardest state to reach is the latched stop. Getting there takes the heating phase and then every attempt running to its end with no accepted strike. Along the way the stimulus places a strike edge inside the heating phase and another inside a blanking gap, to show that neither one cuts a failed attempt short. The bench drives one long directed walk from power-on through every sweep, hold and blank. It measures each phase length cycle by cycle until the stop latches. After that, randomly timed strike pulses of random width land at random points of the sweep and hold. Pulses one cycle short of the minimum width are also sent, to probe the acceptance boundary.

// File: rtl/lamp_start_seq.sv
module lamp_start_seq #(
  parameter int unsigned STEP_CYC     = 156250,
  parameter int unsigned SWEEP_STEPS  = 64,
  parameter int unsigned RECYCLE_CYC  = 12500000,
  parameter int unsigned PH_RATIO     = 16,
  parameter int unsigned BLANK_CYC    = 1000000,
  parameter int unsigned MIN_HIGH_CYC = 100,
  parameter int unsigned MAX_TRIES    = 4
) (
  input  logic                           clk,
  input  logic                           por,
  input  logic                           rst_n,
  input  logic                           strike_in,
  output logic [1:0]                     freq_sel,
  output logic [$clog2(SWEEP_STEPS)-1:0] sweep_step,
  output logic                           bridge_en,
  output logic                           preheat_o,
  output logic                           running_o,
  output logic                           stopped_o
);
  localparam int unsigned PRE_CYC = PH_RATIO * RECYCLE_CYC;
  localparam int unsigned SWP_CYC = STEP_CYC * SWEEP_STEPS;
  localparam int TMR_W  = $clog2(PRE_CYC + 1);
  localparam int SC_W   = (STEP_CYC > 1) ? $clog2(STEP_CYC) : 1;
  localparam int STEP_W = $clog2(SWEEP_STEPS);
  localparam int TRY_W  = $clog2(MAX_TRIES + 1);
  localparam int HI_W   = $clog2(MIN_HIGH_CYC + 1);

  localparam logic [TMR_W-1:0]  PRE_LAST = TMR_W'(PRE_CYC - 1);
  localparam logic [TMR_W-1:0]  SWP_LAST = TMR_W'(SWP_CYC - 1);
  localparam logic [TMR_W-1:0]  REC_LAST = TMR_W'(RECYCLE_CYC - 1);
  localparam logic [TMR_W-1:0]  BLK_LAST = TMR_W'(BLANK_CYC - 1);
  localparam logic [SC_W-1:0]   SC_LAST  = SC_W'(STEP_CYC - 1);
  localparam logic [STEP_W-1:0] STEP_TOP = STEP_W'(SWEEP_STEPS - 1);
  localparam logic [TRY_W-1:0]  TRY_LAST = TRY_W'(MAX_TRIES - 1);
  localparam logic [HI_W-1:0]   HI_MIN   = HI_W'(MIN_HIGH_CYC);

  typedef enum logic [2:0] {
    ST_IDLE, ST_HEAT, ST_SWEEP, ST_HOLD, ST_BLANK, ST_RUN, ST_STOP
  } state_t;

  state_t             st;
  logic               need_heat;
  logic [1:0]         rs, ss;
  logic               sd;
  logic [HI_W-1:0]    hi;
  logic [TMR_W-1:0]   tmr;
  logic [SC_W-1:0]    sc;
  logic [STEP_W-1:0]  step;
  logic [TRY_W-1:0]   tries;
  logic               strike;

  assign strike = sd & ~ss[1] & (hi >= HI_MIN);

  always_ff @(posedge clk or posedge por) begin
    if (por) begin
      st        <= ST_IDLE;
      need_heat <= 1'b1;
      rs        <= '0;
      ss        <= '0;
      sd        <= 1'b0;
      hi        <= '0;
      tmr       <= '0;
      sc        <= '0;
      step      <= STEP_TOP;
      tries     <= '0;
    end else begin
      rs <= {rs[0], rst_n};
      ss <= {ss[0], strike_in};
      sd <= ss[1];
      if (!ss[1])        hi <= '0;
      else if (hi != HI_MIN) hi <= hi + 1'b1;

      if (!rs[1]) begin
        st  <= ST_IDLE;
        tmr <= '0;
      end else begin
        case (st)
          ST_IDLE: begin
            tmr   <= '0;
            tries <= '0;
            sc    <= '0;
            step  <= STEP_TOP;
            st    <= need_heat ? ST_HEAT : ST_SWEEP;
          end
          ST_HEAT: begin
            tmr <= tmr + 1'b1;
            if (tmr == PRE_LAST) begin
              tmr       <= '0;
              need_heat <= 1'b0;
              st        <= ST_SWEEP;
            end
          end
          ST_SWEEP: begin
            if (strike) st <= ST_RUN;
            else begin
              tmr <= tmr + 1'b1;
              if (sc == SC_LAST) begin
                sc <= '0;
                if (step != '0) step <= step - 1'b1;
              end else sc <= sc + 1'b1;
              if (tmr == SWP_LAST) st <= ST_HOLD;
            end
          end
          ST_HOLD: begin
            if (strike) st <= ST_RUN;
            else if (tmr == REC_LAST) begin
              tmr <= '0;
              if (tries == TRY_LAST) st <= ST_STOP;
              else begin
                tries <= tries + 1'b1;
                st    <= ST_BLANK;
              end
            end else tmr <= tmr + 1'b1;
          end
          ST_BLANK: begin
            tmr <= tmr + 1'b1;
            if (tmr == BLK_LAST) begin
              tmr  <= '0;
              sc   <= '0;
              step <= STEP_TOP;
              st   <= ST_SWEEP;
            end
          end
          default: tmr <= tmr;
        endcase
      end
    end
  end

  always_comb begin
    case (st)
      ST_SWEEP: freq_sel = 2'b01;
      ST_HOLD:  freq_sel = 2'b10;
      ST_RUN:   freq_sel = 2'b11;
      default:  freq_sel = 2'b00;
    endcase
  end

  assign sweep_step = (st == ST_SWEEP) ? step :
                      (st == ST_HOLD || st == ST_RUN) ? '0 : STEP_TOP;
  assign bridge_en  = rst_n & rs[1] & (st != ST_IDLE) & (st != ST_STOP);
  assign preheat_o  = (st == ST_HEAT);
  assign running_o  = (st == ST_RUN);
  assign stopped_o  = (st == ST_STOP);
endmodule

module lamp_start_seq_chk #(
  parameter int STEP_W = 6
) (
  input logic              clk,
  input logic              por,
  input logic              rst_n,
  input logic              rst_s,
  input logic [1:0]        freq_sel,
  input logic [STEP_W-1:0] sweep_step,
  input logic              bridge_en,
  input logic              preheat_o,
  input logic              running_o,
  input logic              stopped_o
);
  // R10
  bridge_off_in_reset_chk: assert property (@(posedge clk) disable iff (por)
    !rst_n |-> !bridge_en);
  // R9
  stop_bridge_off_chk: assert property (@(posedge clk) disable iff (por)
    stopped_o |-> !bridge_en);
  // R9
  stop_sticky_chk: assert property (@(posedge clk) disable iff (por)
    (stopped_o && rst_s) |=> stopped_o);
  // R5
  run_sticky_chk: assert property (@(posedge clk) disable iff (por)
    (running_o && rst_s) |=> running_o);
  // R5
  run_entry_chk: assert property (@(posedge clk) disable iff (por)
    $rose(running_o) |-> ($past(freq_sel) == 2'b01 || $past(freq_sel) == 2'b10));
  // R3
  sweep_monotonic_chk: assert property (@(posedge clk) disable iff (por)
    (freq_sel == 2'b01 && $past(freq_sel) == 2'b01) |-> sweep_step <= $past(sweep_step));
  // R11
  flags_onehot_chk: assert property (@(posedge clk) disable iff (por)
    $onehot0({preheat_o, running_o, stopped_o}));
endmodule

bind lamp_start_seq lamp_start_seq_chk #(.STEP_W($clog2(SWEEP_STEPS))) u_chk (
  .clk(clk), .por(por), .rst_n(rst_n), .rst_s(rs[1]),
  .freq_sel(freq_sel), .sweep_step(sweep_step), .bridge_en(bridge_en),
  .preheat_o(preheat_o), .running_o(running_o), .stopped_o(stopped_o)
);

// File: tb/lamp_start_seq_tb.sv
`timescale 1ns/1ps
module lamp_start_seq_tb;
  localparam int STEP_CYC = 4, SWEEP_STEPS = 8, RECYCLE_CYC = 48, PH_RATIO = 4;
  localparam int BLANK_CYC = 10, MIN_HIGH_CYC = 5, MAX_TRIES = 4;
  localparam int SWP_CYC = STEP_CYC * SWEEP_STEPS;

  logic clk = 1'b0, por = 1'b1, rst_n = 1'b1, strike_in = 1'b0;
  logic [1:0] freq_sel;
  logic [2:0] sweep_step;
  logic bridge_en, preheat_o, running_o, stopped_o;
  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  lamp_start_seq #(.STEP_CYC(STEP_CYC), .SWEEP_STEPS(SWEEP_STEPS), .RECYCLE_CYC(RECYCLE_CYC),
    .PH_RATIO(PH_RATIO), .BLANK_CYC(BLANK_CYC), .MIN_HIGH_CYC(MIN_HIGH_CYC),
    .MAX_TRIES(MAX_TRIES)) u_dut (
    .clk(clk), .por(por), .rst_n(rst_n), .strike_in(strike_in), .freq_sel(freq_sel),
    .sweep_step(sweep_step), .bridge_en(bridge_en), .preheat_o(preheat_o),
    .running_o(running_o), .stopped_o(stopped_o));

  function automatic int exp_step(input int i);
    return SWEEP_STEPS - 1 - i / STEP_CYC;
  endfunction

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic count_code(input logic [1:0] code, output int n);
    n = 0;
    while (freq_sel == code && n < 2000) begin n++; tick(); end
  endtask

  task automatic wait_code(input logic [1:0] code);
    int g = 0;
    while (freq_sel != code && g < 2000) begin g++; tick(); end
  endtask

  task automatic pin_reset();
    rst_n = 1'b0;
    #1;
    chk(bridge_en == 1'b0, "R10 bridge off without edge", bridge_en, 0);
    repeat (4) tick();
    chk({preheat_o, running_o, stopped_o} == 3'b000, "R10 flags clear", {preheat_o, running_o, stopped_o}, 0);
    rst_n = 1'b1;
  endtask

  task automatic strike_pulse(input int w);
    strike_in = 1'b1;
    repeat (w) tick();
    strike_in = 1'b0;
  endtask

  initial begin
    int n, sweeps, seen_heat, d, w, hd;
    void'($urandom(32'd20240611));
    repeat (3) tick();
    // R11
    chk({bridge_en, preheat_o, running_o, stopped_o} == 4'b0, "R11 power-on state",
        {bridge_en, preheat_o, running_o, stopped_o}, 0);
    por = 1'b0;
    tick();
    chk(bridge_en == 1'b0, "R11 after por", bridge_en, 0);
    n = 0;
    while (!preheat_o && n < 20) begin n++; tick(); end
    // R1 heating length, with a strike pulse inside it (R7)
    n = 0;
    while (preheat_o && n < 2000) begin
      if (n == 20) strike_in = 1'b1;
      if (n == 30) strike_in = 1'b0;
      if (n == 5) chk(freq_sel == 2'b00 && bridge_en, "R1 heating at f1", freq_sel, 0);
      n++;
      tick();
    end
    chk(n == PH_RATIO * RECYCLE_CYC, "R1 heating length", n, PH_RATIO * RECYCLE_CYC);
    chk(freq_sel == 2'b01, "R7 heat edge ignored, sweep follows", freq_sel, 1);

    sweeps = 0;
    for (int a = 0; a < MAX_TRIES; a++) begin
      bit step_ok = 1'b1;
      int bad = 0;
      n = 0;
      sweeps++;
      while (freq_sel == 2'b01 && n < 2000) begin
        if (sweep_step != 3'(exp_step(n)) && step_ok) begin step_ok = 1'b0; bad = n; end
        n++;
        tick();
      end
      chk(n == SWP_CYC, "R3 sweep length", n, SWP_CYC);
      chk(step_ok, "R3 step sequence", bad, exp_step(bad));
      count_code(2'b10, n);
      chk(n == RECYCLE_CYC - SWP_CYC, "R4 f2 hold length", n, RECYCLE_CYC - SWP_CYC);
      if (a < MAX_TRIES - 1) begin
        n = 0;
        while (freq_sel == 2'b00 && n < 2000) begin
          if (a == 0 && n == 0) strike_in = 1'b1;
          if (a == 0 && n == 6) strike_in = 1'b0;
          if (n == 1) chk(bridge_en && !preheat_o, "R8 blank bridge on", bridge_en, 1);
          n++;
          tick();
        end
        chk(n == BLANK_CYC, "R8 blank length", n, BLANK_CYC);
        if (a == 0) chk(freq_sel == 2'b01, "R7 blank edge ignored", freq_sel, 1);
      end
    end
    chk(stopped_o && !bridge_en, "R9 stop latched", {stopped_o, bridge_en}, 2);
    chk(sweeps == MAX_TRIES, "R9 attempt count", sweeps, MAX_TRIES);
    strike_pulse(8);
    repeat (20) tick();
    chk(stopped_o && freq_sel == 2'b00, "R9 stop holds", stopped_o, 1);

    // R2 pin reset restarts without heating
    pin_reset();
    seen_heat = 0;
    n = 0;
    while (freq_sel != 2'b01 && n < 20) begin
      if (preheat_o) seen_heat = 1;
      n++;
      tick();
    end
    chk(freq_sel == 2'b01 && seen_heat == 0, "R2 sweep without heating", seen_heat, 0);

    // R6 short pulse, then R5 exact minimum accepted
    tick();
    strike_pulse(MIN_HIGH_CYC - 1);
    repeat (4) tick();
    chk(!running_o, "R6 short pulse rejected", running_o, 0);
    strike_pulse(MIN_HIGH_CYC);
    tick(); tick();
    chk(!running_o, "R5 not before third edge", running_o, 0);
    tick();
    chk(running_o && freq_sel == 2'b11 && bridge_en, "R5 minimum width accepted", freq_sel, 3);
    repeat (100) tick();
    chk(running_o && freq_sel == 2'b11, "R5 operating holds", freq_sel, 3);

    // R5 random strike times across sweep and hold
    for (int t = 0; t < 12; t++) begin
      pin_reset();
      wait_code(2'b01);
      w = int'($urandom_range(MIN_HIGH_CYC, MIN_HIGH_CYC + 6));
      d = int'($urandom_range(0, RECYCLE_CYC - w - 4));
      repeat (d) tick();
      hd = d;
      strike_pulse(w);
      tick(); tick();
      chk(!running_o, "R5 random latency early", hd, w);
      tick();
      chk(running_o && freq_sel == 2'b11, "R5 random strike accepted", freq_sel, 3);
    end
    // R6 random short pulse in hold
    pin_reset();
    wait_code(2'b10);
    strike_pulse(int'($urandom_range(1, MIN_HIGH_CYC - 1)));
    repeat (4) tick();
    chk(freq_sel == 2'b10, "R6 short pulse in hold", freq_sel, 2);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule